// File: doc/BRIEF.md
# TDD Terminal Sync Generator

This block keeps the frame timing of two time-division-duplex radio terminals in step. Each terminal holds one copy of the block, and the two copies are wired crosswise through a pair of request and acknowledge lines. A register sets the role of each copy. The master copy times an interval on its own. At the end of each interval it raises a request toward the peer. The slave copy answers each new request with an acknowledge. It also emits a single-cycle local sync pulse, which the frame counter beside it uses to realign.

Software controls the block through a small write port. One register selects master or slave, and a 32-bit register sets the repeat interval in clock cycles. The block produces pulses only while TDD operation is enabled. It synchronises both incoming handshake lines through a chain of flops, because the two terminals run on unrelated clocks. The handshake is four-phase. An interval that ends while a handshake is still open is discarded and not stored for later.

Top module: `tdd_sync_gen`

## Requirements
- R1: After reset the terminal is a slave, the interval register reads as zero, and `req_o`, `ack_o` and `sync_pulse_o` are all low.
- R2: A write to address 0x50 sets the role from data bit 0 (1 = master, 0 = slave). A write to any address other than 0x50 or 0x54 leaves the role and the interval unchanged.
- R3: A write to address 0x54 loads a 32-bit interval P in clock cycles. In the first cycle in which the terminal is both master and enabled, an expiry occurs. Further expiries follow every P cycles. An expiry that starts a handshake shows `sync_pulse_o` high for one cycle on the next clock edge.
- R4: When P is 0, the master emits exactly one pulse per enable period and no more.
- R5: The master raises `req_o` on the same edge as its pulse. It holds `req_o` until the synchronised acknowledge is high, then drops it. It starts no new request until the synchronised acknowledge has returned low.
- R6: An expiry that occurs while a handshake is open is dropped. It produces no pulse and no request.
- R7: A slave raises `ack_o` three clock edges after `peer_req_i` rises, and holds it while the synchronised request stays high. If the slave is enabled, it also emits a one-cycle `sync_pulse_o` on the same edge as `ack_o` rises, once for each rising edge of the request.
- R8: While TDD is disabled, the master holds `req_o` low from the next edge, restarts its interval, and emits no pulse. A disabled slave still acknowledges but emits no pulse.
- R9: A master never drives `ack_o` and ignores `peer_req_i`. A slave never drives `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| tdd_en | input | 1 | TDD operation enable |
| peer_req_i | input | 1 | Request arriving from the peer master (asynchronous) |
| peer_ack_i | input | 1 | Acknowledge arriving from the peer slave (asynchronous) |
| req_o | output | 1 | Request toward the peer slave |
| ack_o | output | 1 | Acknowledge toward the peer master |
| sync_pulse_o | output | 1 | One-cycle local frame sync pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a two-stage synchroniser and a 32-bit interval. It sets the interval at run time to 0, 4 and 20 cycles. The 20-cycle interval shows five clean expiries in a 100-cycle window. The 4-cycle interval is shorter than one full handshake with a three-cycle peer delay, so it reaches the dropped-expiry case. The value 0 shows the single-shot case.

// File: rtl/tdd_sync_pkg.sv
package tdd_sync_pkg;
  localparam int PERIOD_W = 32;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_REQ     = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;

  // Expiry: the first active cycle, or the last cycle of a non-zero interval.
  function automatic logic period_due(input logic started,
                                      input logic [PERIOD_W-1:0] period,
                                      input logic [PERIOD_W-1:0] count);
    return !started || ((period != '0) && (count == period - 1'b1));
  endfunction

  function automatic logic edge_up(input logic now, input logic prev);
    return now & ~prev;
  endfunction
endpackage

// File: rtl/tdd_sync_cdc.sv
module tdd_sync_cdc #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/tdd_sync_regs.sv
module tdd_sync_regs #(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter logic [7:0]  ROLE_ADDR   = 8'h50,
  parameter logic [7:0]  PERIOD_ADDR = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              role_master,
  output logic [DATA_W-1:0] period
);
  logic hit_role, hit_period;
  assign hit_role   = cfg_wr && (cfg_addr == ADDR_W'(ROLE_ADDR));
  assign hit_period = cfg_wr && (cfg_addr == ADDR_W'(PERIOD_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_master <= 1'b0;
      period      <= '0;
    end else begin
      if (hit_role)   role_master <= cfg_wdata[0];
      if (hit_period) period      <= cfg_wdata;
    end
  end

  p_role_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit_role) |=> $stable(role_master));
endmodule

// File: rtl/tdd_sync_master.sv
module tdd_sync_master
  import tdd_sync_pkg::*;
#(
  parameter int CNT_W = PERIOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] period,
  input  logic             ack_s,
  output logic             req_o,
  output logic             sync_o
);
  hs_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             started_q;
  logic             sync_q;
  logic             due, launch;

  assign due    = period_due(started_q, period, cnt_q);
  assign launch = due && (state_q == HS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      cnt_q     <= '0;
      started_q <= 1'b0;
      sync_q    <= 1'b0;
    end else if (!active) begin
      state_q   <= HS_IDLE;
      cnt_q     <= '0;
      started_q <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      cnt_q     <= due ? '0 : cnt_q + 1'b1;
      started_q <= 1'b1;
      sync_q    <= launch;
      unique case (state_q)
        HS_IDLE:    if (launch) state_q <= HS_REQ;
        HS_REQ:     if (ack_s)  state_q <= HS_RELEASE;
        HS_RELEASE: if (!ack_s) state_q <= HS_IDLE;
        default:                state_q <= HS_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == HS_REQ);
  assign sync_o = sync_q;

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_o && !ack_s) |=> req_o);
  p_pulse_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> sync_o);
  p_drop_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state_q != HS_IDLE) |=> !sync_o);
  p_en_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!req_o && !sync_o));
endmodule

// File: rtl/tdd_sync_slave.sv
module tdd_sync_slave
  import tdd_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic is_slave,
  input  logic tdd_en,
  input  logic req_s,
  output logic ack_o,
  output logic sync_o
);
  logic req_d_q, ack_q, sync_q, req_rise;

  assign req_rise = edge_up(req_s, req_d_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= 1'b0;
      ack_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      req_d_q <= req_s;
      ack_q   <= is_slave && req_s;
      sync_q  <= is_slave && tdd_en && req_rise;
    end
  end

  assign ack_o  = ack_q;
  assign sync_o = sync_q;

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);
  p_pulse_has_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> ack_o);
  p_no_pulse_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tdd_en |=> !sync_o);
endmodule

// File: rtl/tdd_sync_gen.sv
module tdd_sync_gen
  import tdd_sync_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ROLE_ADDR   = 8'h50,
  parameter logic [7:0] PERIOD_ADDR = 8'h54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [PERIOD_W-1:0] cfg_wdata,
  input  logic                tdd_en,
  input  logic                peer_req_i,
  input  logic                peer_ack_i,
  output logic                req_o,
  output logic                ack_o,
  output logic                sync_pulse_o
);
  localparam int LINES = 2;

  logic                role_master;
  logic [PERIOD_W-1:0] period;
  logic [LINES-1:0]    lines_s;
  logic                req_s, ack_s, m_active;
  logic                m_req, m_sync, s_ack, s_sync;

  tdd_sync_regs #(
    .ADDR_W(ADDR_W), .DATA_W(PERIOD_W),
    .ROLE_ADDR(ROLE_ADDR), .PERIOD_ADDR(PERIOD_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .role_master(role_master), .period(period)
  );

  tdd_sync_cdc #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) cdc_i (
    .clk(clk), .rst_n(rst_n),
    .async_i({peer_ack_i, peer_req_i}), .sync_o(lines_s)
  );
  assign req_s = lines_s[0];
  assign ack_s = lines_s[1];

  assign m_active = role_master && tdd_en;

  tdd_sync_master #(.CNT_W(PERIOD_W)) master_i (
    .clk(clk), .rst_n(rst_n), .active(m_active), .period(period),
    .ack_s(ack_s), .req_o(m_req), .sync_o(m_sync)
  );

  tdd_sync_slave slave_i (
    .clk(clk), .rst_n(rst_n), .is_slave(!role_master), .tdd_en(tdd_en),
    .req_s(req_s), .ack_o(s_ack), .sync_o(s_sync)
  );

  assign req_o        = m_req;
  assign ack_o        = s_ack;
  assign sync_pulse_o = m_sync | s_sync;

  p_no_req_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !role_master |=> !req_o);
  p_no_ack_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
    role_master |=> !ack_o);
  p_one_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_sync && s_sync));
endmodule

// File: tb/tdd_sync_gen_tb_top.sv
module tdd_sync_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tdd_en = 1'b0;
  logic        peer_req_i = 1'b0;
  logic        peer_ack_i = 1'b0;
  logic        req_o, ack_o, sync_pulse_o;

  int compared = 0;
  int mismatched = 0;
  int pulses = 0;
  bit cmp_on = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tdd_sync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tdd_en(tdd_en), .peer_req_i(peer_req_i),
    .peer_ack_i(peer_ack_i), .req_o(req_o), .ack_o(ack_o),
    .sync_pulse_o(sync_pulse_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, evaluated on every rising edge.
  bit          m_master, m_started, e_req, e_ack, e_msync, e_ssync;
  int unsigned m_period, m_cnt;
  int          m_phase;
  bit          ackq[$];
  bit          reqq[$];
  bit          a_s, r_s, r_d, act, expire, launch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_master = 0; m_period = 0; m_cnt = 0; m_started = 0; m_phase = 0;
      e_req = 0; e_ack = 0; e_msync = 0; e_ssync = 0;
      ackq = '{0, 0};
      reqq = '{0, 0, 0};
    end else begin
      a_s = ackq[0]; r_d = reqq[0]; r_s = reqq[1];
      ackq.push_back(peer_ack_i); void'(ackq.pop_front());
      reqq.push_back(peer_req_i); void'(reqq.pop_front());
      act = m_master && tdd_en;
      launch = 0;
      if (!act) begin
        m_cnt = 0; m_started = 0; m_phase = 0;
      end else begin
        expire = !m_started || (m_period != 0 && m_cnt == m_period - 1);
        m_cnt = expire ? 0 : m_cnt + 1;
        m_started = 1;
        if (m_phase == 0) begin
          if (expire) begin launch = 1; m_phase = 1; end
        end else if (m_phase == 1) begin
          if (a_s) m_phase = 2;
        end else begin
          if (!a_s) m_phase = 0;
        end
      end
      e_req   = (m_phase == 1);
      e_msync = launch;
      e_ack   = !m_master && r_s;
      e_ssync = !m_master && tdd_en && r_s && !r_d;
      if (cfg_wr && cfg_addr == 8'h50) m_master = cfg_wdata[0];
      if (cfg_wr && cfg_addr == 8'h54) m_period = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R5 req_o", req_o, e_req);
      chk("R7 ack_o", ack_o, e_ack);
      chk("R3 sync_pulse_o", sync_pulse_o, e_msync | e_ssync);
    end
    if (sync_pulse_o) pulses++;
  end

  // Behavioural peer slave: echoes req_o back after a fixed delay.
  logic [7:0] ack_sr = '0;
  always @(negedge clk) begin
    ack_sr     <= {ack_sr[6:0], req_o};
    peer_ack_i <= ack_sr[2];
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic run_master(input int unsigned per, input int exp_lo, input int exp_hi, input string tag);
    wr(8'h54, per);
    @(negedge clk); tdd_en = 1; pulses = 0;
    repeat (100) @(negedge clk);
    tdd_en = 0;
    compared++;
    if (pulses < exp_lo || pulses > exp_hi) begin
      mismatched++;
      $display("FAIL %s: actual %0d pulses expected %0d..%0d", tag, pulses, exp_lo, exp_hi);
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req_o reset", req_o, 0);
    chk("R1 ack_o reset", ack_o, 0);
    chk("R1 sync reset", sync_pulse_o, 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R2: write elsewhere does not make the terminal master
    wr(8'h58, 32'h1);
    tdd_en = 1; pulses = 0;
    repeat (20) @(negedge clk);
    chk("R2 no role change", pulses, 0);
    chk("R2 req_o stays low", req_o, 0);
    tdd_en = 0;
    // R1: interval resets to zero -> single shot once master
    wr(8'h50, 32'h1);
    run_master(0, 1, 1, "R1 default interval zero");
    run_master(20, 5, 5, "R3 interval 20");
    run_master(0, 1, 1, "R4 single pulse");
    run_master(4, 1, 24, "R6 drops under short interval");
    // R8: disabled master stays silent
    pulses = 0;
    repeat (40) @(negedge clk);
    chk("R8 no pulses when disabled", pulses, 0);
    chk("R8 req_o low when disabled", req_o, 0);
    // R9: master ignores peer request
    peer_req_i = 1; repeat (8) @(negedge clk);
    chk("R9 master no ack", ack_o, 0);
    peer_req_i = 0; repeat (8) @(negedge clk);
    chk("R9 master no pulse from peer", pulses, 0);
    // R7: slave answers request
    wr(8'h50, 32'h0);
    tdd_en = 1; pulses = 0;
    repeat (4) @(negedge clk);
    peer_req_i = 1;
    repeat (2) @(negedge clk);
    chk("R7 ack not before third edge", ack_o, 0);
    @(negedge clk);
    chk("R7 ack on third edge", ack_o, 1);
    chk("R7 pulse on third edge", sync_pulse_o, 1);
    repeat (8) @(negedge clk);
    chk("R7 ack held", ack_o, 1);
    chk("R7 one pulse per edge", pulses, 1);
    chk("R9 slave no req", req_o, 0);
    peer_req_i = 0;
    repeat (5) @(negedge clk);
    chk("R7 ack released", ack_o, 0);
    // R8: disabled slave acknowledges without pulse
    tdd_en = 0; pulses = 0;
    peer_req_i = 1; repeat (6) @(negedge clk);
    chk("R8 disabled slave acks", ack_o, 1);
    chk("R8 disabled slave no pulse", pulses, 0);
    peer_req_i = 0; repeat (6) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule